// File: doc/BRIEF.md
# ACPI Power Management Event Controller

This block keeps a 16-bit power-management status register whose bits are set by hardware event inputs and cleared by software writing ones. A matching enable register selects which status bits may raise interrupts. In the working state, any enabled status bit raises a system control interrupt (SCI) or an active-low system management interrupt (SMI#). A control bit chooses between the two at run time. Two status bits (8, the power button, and 10, the alarm) may also wake the system from sleep. Bit 5 can never raise SMI#. Bit 0 can interrupt but never wakes.

A small state tracker follows the system through working, sleeping and soft-off. Software enters sleep through a self-clearing control bit. A wake sets the top status bit (wake status) and returns the system to working. The `pwr_fail_i` pulse stands for a power loss and its return. After it, the system either resumes working or parks in soft-off, depending on an enable kept in the always-on domain. The registers sit in three reset domains: core (warm reset), resume, and always-on.

The register port is a simple I/O port. A request is taken in every cycle that `io_valid_i` is high. There is no back-pressure, so no ready signal exists. Writes take effect at the next clock edge. Read data is combinational and is valid in the same cycle as the request.

Top module: `pmevt_ctrl`

## Requirements
- R1: After all resets, the status, enable and control registers read 0 and the state reads 0 (working). `sci_o` and `wake_o` are low and `smi_n_o` is high.
- R2: Address map on `io_addr_i`:
  - Address 0 is status. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
  - Address 1 is enable. It is read/write, and bit 15 always reads 0.
  - Address 2 is control: bit0 selects SCI routing, bit1 requests sleep and always reads 0, bit2 is the after-failure soft-off enable.
  - Address 3 reads the state in bits [1:0]: 0 working, 1 sleeping, 2 soft-off.
- R3: When a hardware set and a software clear of the same status bit arrive in the same cycle, the bit ends up set. `evt_i[i]` sets status bit i for i in 0..14. `evt_i[15]` is ignored.
- R4: Writing control with bit1 set in the working state moves the system to sleeping at that edge.
  - While sleeping, status bit 8 or 10 with its enable set raises `wake_o` combinationally.
  - At the next edge the state becomes working and status bit 15 is set.
  - No other status bit wakes the system.
- R5: In the working state, any set and enabled status bit among 0..14 holds `sci_o` high when control bit0 is 1. When control bit0 is 0, any such bit except bit 5 holds `smi_n_o` low. The output returns to idle once software clears the bit.
- R6: Status bit 5 never drives `smi_n_o` low but may drive `sci_o`. Status bit 0 interrupts but never wakes.
- R7: Outside the working state, neither interrupt is asserted. Pending enabled bits assert it once the system is working again.
- R8: A core reset clears status and enable bits 0..7 and control bit0 only. Status bits 8..15 and the state are kept.
- R9: A resume reset clears status bits 8..15 except bit 11 and enable bits 8..15 except bit 10. It also returns the state to working.
- R10: `pwr_fail_i` clears all status and enable bits except status bit 11 and enable bit 10. It also clears control bit0. With control bit2 clear, the state becomes working and wake status stays clear.
- R11: `pwr_fail_i` with control bit2 set moves the system to soft-off. From soft-off, status bit 8 wakes even without its enable, and status bit 10 wakes through its retained enable. Either wake sets status bit 15.
- R12: Status bit 11, enable bit 10 and control bit2 survive `pwr_fail_i`, core reset and resume reset. Only the always-on reset clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| core_rst_n | input | 1 | Warm core reset, active low, asynchronous |
| rsm_rst_n | input | 1 | Resume-domain reset, active low, asynchronous |
| aon_rst_n | input | 1 | Always-on domain reset, active low, asynchronous |
| pwr_fail_i | input | 1 | One-cycle pulse: power was lost and has returned |
| evt_i | input | 16 | Hardware event pulses, bit i sets status bit i |
| io_valid_i | input | 1 | I/O request valid |
| io_write_i | input | 1 | 1 = write, 0 = read |
| io_addr_i | input | 2 | Register address |
| io_wdata_i | input | 16 | Write data |
| io_rdata_o | output | 16 | Read data, valid in the request cycle |
| sci_o | output | 1 | System control interrupt, active high level |
| smi_n_o | output | 1 | System management interrupt, active low level |
| wake_o | output | 1 | Wake request while not working |

## Verification
The bench attacks the following corner cases:
- **Set against clear in one cycle.** If the clear won, bit 2 would read back as 0.
- **Zero-write to status.** A design that treats status as plain read/write would lose pending bits.
- **Bit 5 under SMI routing.** A design that routes bit 5 to SMI# would hold `smi_n_o` low.
- **Bit 0 enabled while sleeping.** A wrongly masked bit 0 would wake the system.
- **Reset-domain boundaries.** A core reset must spare status bit 15. A resume reset must spare bit 11 and enable bit 10. A domain mistake shows up as a wrong readback.
- **Both failure paths.** If the retained enable were cleared along with everything else, the system would not reach soft-off and the bit-10 wake would not happen. A power-button wake that checked the cleared enable would leave the system in soft-off.

// File: rtl/pmevt_pkg.sv
package pmevt_pkg;
  typedef enum logic [1:0] {
    PS_WORK  = 2'd0,
    PS_SLEEP = 2'd1,
    PS_OFF   = 2'd2
  } pstate_e;

  typedef enum logic [1:0] {
    RA_STS   = 2'd0,
    RA_EN    = 2'd1,
    RA_CTL   = 2'd2,
    RA_STATE = 2'd3
  } raddr_e;

  localparam int CTL_ROUTE_BIT = 0;
  localparam int CTL_SLEEP_BIT = 1;
  localparam int CTL_G3_BIT    = 2;
endpackage

// File: rtl/pmevt_bank.sv
// Register bank with a reset domain chosen per bit.
module pmevt_bank #(
  parameter int           W         = 16,
  parameter logic [W-1:0] IMPL_MASK = '1,
  parameter logic [W-1:0] CORE_MASK = '0,
  parameter logic [W-1:0] AON_MASK  = '0,
  parameter bit           W1C       = 1'b1
) (
  input  logic         clk,
  input  logic         core_rst_n,
  input  logic         rsm_rst_n,
  input  logic         aon_rst_n,
  input  logic         pwr_fail_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic r;
    logic nxt;

    // Priority: not implemented, then power loss, then hardware set,
    // then the software write.
    always_comb begin
      if (!IMPL_MASK[i])                  nxt = 1'b0;
      else if (pwr_fail_i && !AON_MASK[i]) nxt = 1'b0;
      else if (set_i[i])                  nxt = 1'b1;
      else if (wr_i)                      nxt = W1C ? (r & ~wdata_i[i]) : wdata_i[i];
      else                                nxt = r;
    end

    if (AON_MASK[i]) begin : g_aon
      always_ff @(posedge clk or negedge aon_rst_n)
        if (!aon_rst_n) r <= 1'b0;
        else            r <= nxt;
    end else if (CORE_MASK[i]) begin : g_core
      always_ff @(posedge clk or negedge core_rst_n)
        if (!core_rst_n) r <= 1'b0;
        else             r <= nxt;
    end else begin : g_rsm
      always_ff @(posedge clk or negedge rsm_rst_n)
        if (!rsm_rst_n) r <= 1'b0;
        else            r <= nxt;
    end

    assign q_o[i] = r;
  end

  // R2: with no write, no set and no power loss the bank holds its value.
  p_hold_r2: assert property (@(posedge clk)
    disable iff (!core_rst_n || !rsm_rst_n || !aon_rst_n)
    (!pwr_fail_i && !wr_i && set_i == '0) |=> (q_o == $past(q_o)));

  // R3: a hardware set always lands, even against a same-cycle clear.
  p_set_wins_r3: assert property (@(posedge clk)
    disable iff (!core_rst_n || !rsm_rst_n || !aon_rst_n)
    (!pwr_fail_i && (set_i & IMPL_MASK) != '0)
      |=> ((q_o & $past(set_i & IMPL_MASK)) == $past(set_i & IMPL_MASK)));
endmodule

// File: rtl/pmevt_route.sv
// Routes status bits to SCI, SMI# and the wake request.
module pmevt_route
  import pmevt_pkg::*;
#(
  parameter int           W          = 16,
  parameter logic [W-1:0] WAKE_MASK  = 16'h0500,
  parameter logic [W-1:0] SMI_BLOCK  = 16'h0020,
  parameter int           PWRBTN_BIT = 8
) (
  input  logic [W-1:0] sts_i,
  input  logic [W-1:0] en_i,
  input  pstate_e      state_i,
  input  logic         route_sci_i,
  output logic         sci_o,
  output logic         smi_n_o,
  output logic         wake_hit_o
);
  localparam int WSTS = W - 1;

  logic [W-1:0] pend;
  logic         any_sci, any_smi, working, wake_en_hit;

  always_comb begin
    pend       = sts_i & en_i;
    pend[WSTS] = 1'b0;
  end

  assign any_sci     = |pend;
  assign any_smi     = |(pend & ~SMI_BLOCK);
  assign working     = (state_i == PS_WORK);
  assign wake_en_hit = |(pend & WAKE_MASK);

  assign sci_o   = working & route_sci_i & any_sci;
  assign smi_n_o = ~(working & ~route_sci_i & any_smi);

  always_comb begin
    case (state_i)
      PS_SLEEP: wake_hit_o = wake_en_hit;
      PS_OFF:   wake_hit_o = wake_en_hit | sts_i[PWRBTN_BIT];
      default:  wake_hit_o = 1'b0;
    endcase
  end

  // R5: the two interrupt outputs are never active together.
  always_comb begin
    p_excl_r5: assert (!(sci_o && !smi_n_o));
  end
endmodule

// File: rtl/pmevt_fsm.sv
// Sleep-state tracker; lives in the resume domain.
module pmevt_fsm
  import pmevt_pkg::*;
(
  input  logic    clk,
  input  logic    rsm_rst_n,
  input  logic    pwr_fail_i,
  input  logic    ret_g3_i,
  input  logic    sleep_go_i,
  input  logic    wake_hit_i,
  output pstate_e state_o,
  output logic    wake_set_o
);
  pstate_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (pwr_fail_i)                             state_d = ret_g3_i ? PS_OFF : PS_WORK;
    else if (state_q == PS_WORK && sleep_go_i)  state_d = PS_SLEEP;
    else if (state_q != PS_WORK && wake_hit_i)  state_d = PS_WORK;
  end

  always_ff @(posedge clk or negedge rsm_rst_n)
    if (!rsm_rst_n) state_q <= PS_WORK;
    else            state_q <= state_d;

  assign state_o    = state_q;
  assign wake_set_o = (state_q != PS_WORK) & wake_hit_i;

  // R4: a sleep request from working is obeyed at the next edge.
  p_sleep_entry_r4: assert property (@(posedge clk) disable iff (!rsm_rst_n)
    (state_q == PS_WORK && sleep_go_i && !pwr_fail_i) |=> (state_q == PS_SLEEP));

  // R4: a wake hit outside working returns to working.
  p_wake_exit_r4: assert property (@(posedge clk) disable iff (!rsm_rst_n)
    (state_q != PS_WORK && wake_hit_i && !pwr_fail_i) |=> (state_q == PS_WORK));

  // R10 / R11: a power loss lands in the state the retained enable selects.
  p_fail_dest_r11: assert property (@(posedge clk) disable iff (!rsm_rst_n)
    pwr_fail_i |=> (state_q == ($past(ret_g3_i) ? PS_OFF : PS_WORK)));
endmodule

// File: rtl/pmevt_ctrl.sv
module pmevt_ctrl
  import pmevt_pkg::*;
#(
  parameter int                STS_W        = 16,
  parameter logic [STS_W-1:0]  WAKE_MASK    = 16'h0500,
  parameter logic [STS_W-1:0]  SMI_BLOCK    = 16'h0020,
  parameter logic [STS_W-1:0]  CORE_MASK    = 16'h00FF,
  parameter logic [STS_W-1:0]  AON_STS_MASK = 16'h0800,
  parameter logic [STS_W-1:0]  AON_EN_MASK  = 16'h0400,
  parameter int                PWRBTN_BIT   = 8
) (
  input  logic             clk,
  input  logic             core_rst_n,
  input  logic             rsm_rst_n,
  input  logic             aon_rst_n,
  input  logic             pwr_fail_i,
  input  logic [STS_W-1:0] evt_i,
  input  logic             io_valid_i,
  input  logic             io_write_i,
  input  logic [1:0]       io_addr_i,
  input  logic [STS_W-1:0] io_wdata_i,
  output logic [STS_W-1:0] io_rdata_o,
  output logic             sci_o,
  output logic             smi_n_o,
  output logic             wake_o
);
  localparam int               WSTS     = STS_W - 1;
  localparam logic [STS_W-1:0] HW_MASK  = ~(STS_W'(1) << WSTS);
  localparam logic [STS_W-1:0] EN_IMPL  = HW_MASK;

  logic             wr_sts, wr_en, wr_ctl, sleep_go;
  logic [STS_W-1:0] sts_q, en_q, sts_set;
  logic             route_q, g3_q, wake_set;
  pstate_e          state_q;

  assign wr_sts   = io_valid_i & io_write_i & (io_addr_i == RA_STS);
  assign wr_en    = io_valid_i & io_write_i & (io_addr_i == RA_EN);
  assign wr_ctl   = io_valid_i & io_write_i & (io_addr_i == RA_CTL);
  assign sleep_go = wr_ctl & io_wdata_i[CTL_SLEEP_BIT];

  always_comb begin
    sts_set       = evt_i & HW_MASK;
    sts_set[WSTS] = wake_set;
  end

  pmevt_bank #(
    .W(STS_W), .IMPL_MASK('1), .CORE_MASK(CORE_MASK),
    .AON_MASK(AON_STS_MASK), .W1C(1'b1)
  ) u_sts (
    .clk(clk), .core_rst_n(core_rst_n), .rsm_rst_n(rsm_rst_n), .aon_rst_n(aon_rst_n),
    .pwr_fail_i(pwr_fail_i), .wr_i(wr_sts), .wdata_i(io_wdata_i),
    .set_i(sts_set), .q_o(sts_q)
  );

  pmevt_bank #(
    .W(STS_W), .IMPL_MASK(EN_IMPL), .CORE_MASK(CORE_MASK),
    .AON_MASK(AON_EN_MASK), .W1C(1'b0)
  ) u_en (
    .clk(clk), .core_rst_n(core_rst_n), .rsm_rst_n(rsm_rst_n), .aon_rst_n(aon_rst_n),
    .pwr_fail_i(pwr_fail_i), .wr_i(wr_en), .wdata_i(io_wdata_i),
    .set_i('0), .q_o(en_q)
  );

  // Control: routing select in the core domain, failure enable always-on.
  always_ff @(posedge clk or negedge core_rst_n)
    if (!core_rst_n)    route_q <= 1'b0;
    else if (pwr_fail_i) route_q <= 1'b0;
    else if (wr_ctl)    route_q <= io_wdata_i[CTL_ROUTE_BIT];

  always_ff @(posedge clk or negedge aon_rst_n)
    if (!aon_rst_n)  g3_q <= 1'b0;
    else if (wr_ctl) g3_q <= io_wdata_i[CTL_G3_BIT];

  pmevt_route #(
    .W(STS_W), .WAKE_MASK(WAKE_MASK), .SMI_BLOCK(SMI_BLOCK), .PWRBTN_BIT(PWRBTN_BIT)
  ) u_route (
    .sts_i(sts_q), .en_i(en_q), .state_i(state_q), .route_sci_i(route_q),
    .sci_o(sci_o), .smi_n_o(smi_n_o), .wake_hit_o(wake_o)
  );

  pmevt_fsm u_fsm (
    .clk(clk), .rsm_rst_n(rsm_rst_n), .pwr_fail_i(pwr_fail_i), .ret_g3_i(g3_q),
    .sleep_go_i(sleep_go), .wake_hit_i(wake_o), .state_o(state_q), .wake_set_o(wake_set)
  );

  always_comb begin
    io_rdata_o = '0;
    if (io_valid_i && !io_write_i) begin
      case (io_addr_i)
        RA_STS:   io_rdata_o = sts_q;
        RA_EN:    io_rdata_o = en_q;
        RA_CTL: begin
          io_rdata_o[CTL_ROUTE_BIT] = route_q;
          io_rdata_o[CTL_G3_BIT]    = g3_q;
        end
        default:  io_rdata_o[1:0] = state_q;
      endcase
    end
  end

  // R4: a wake outside working leaves wake status set.
  p_wake_sts_r4: assert property (@(posedge clk)
    disable iff (!core_rst_n || !rsm_rst_n || !aon_rst_n)
    (state_q != PS_WORK && wake_o && !pwr_fail_i) |=> sts_q[WSTS]);

  // R12: the always-on status bit survives a power loss.
  p_aon_keep_r12: assert property (@(posedge clk) disable iff (!aon_rst_n)
    (pwr_fail_i && !wr_sts) |=> ((sts_q & AON_STS_MASK) == ($past(sts_q) & AON_STS_MASK)
                                  || ($past(sts_set) & AON_STS_MASK) != '0));
endmodule

// File: tb/tb_pmevt_ctrl.sv
`timescale 1ns/1ps
module tb_pmevt_ctrl;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic core_rst_n = 1'b0, rsm_rst_n = 1'b0, aon_rst_n = 1'b0, pwr_fail = 1'b0;
  logic io_valid = 1'b0, io_write = 1'b0;
  logic [1:0]  io_addr = 2'd0;
  logic [15:0] io_wdata = '0, evt = '0;
  logic [15:0] io_rdata;
  logic sci, smi_n, wake;

  pmevt_ctrl dut (
    .clk(clk), .core_rst_n(core_rst_n), .rsm_rst_n(rsm_rst_n), .aon_rst_n(aon_rst_n),
    .pwr_fail_i(pwr_fail), .evt_i(evt), .io_valid_i(io_valid), .io_write_i(io_write),
    .io_addr_i(io_addr), .io_wdata_i(io_wdata), .io_rdata_o(io_rdata),
    .sci_o(sci), .smi_n_o(smi_n), .wake_o(wake)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model.
  logic [15:0] m_sts = '0, m_en = '0;
  logic m_route = 1'b0, m_g3 = 1'b0;
  int m_st = 0;

  function automatic logic m_wake();
    logic hit;
    hit = (m_sts & m_en & 16'h0500) != 0;
    if (m_st == 1) return hit;
    if (m_st == 2) return hit || m_sts[8];
    return 1'b0;
  endfunction

  function automatic logic [15:0] m_read(logic [1:0] a);
    case (a)
      2'd0: return m_sts;
      2'd1: return m_en;
      2'd2: return {13'd0, m_g3, 1'b0, m_route};
      default: return 16'(m_st);
    endcase
  endfunction

  always @(posedge clk) begin : ref_model
    logic [15:0] s, e;
    logic r, g, wk, ws, we, wc;
    int st;
    wk = m_wake();
    ws = io_valid && io_write && io_addr == 2'd0;
    we = io_valid && io_write && io_addr == 2'd1;
    wc = io_valid && io_write && io_addr == 2'd2;
    s = m_sts; e = m_en; r = m_route; g = m_g3; st = m_st;
    if (ws) s = s & ~io_wdata;
    if (we) e = io_wdata & 16'h7FFF;
    if (wc) begin r = io_wdata[0]; g = io_wdata[2]; end
    s = s | (evt & 16'h7FFF) | (wk ? 16'h8000 : 16'h0000);
    if (pwr_fail) begin
      s = s & 16'h0800; e = e & 16'h0400; r = 1'b0; st = m_g3 ? 2 : 0;
    end else if (m_st == 0 && wc && io_wdata[1]) st = 1;
    else if (wk) st = 0;
    if (!aon_rst_n)  begin s[11] = 1'b0; e[10] = 1'b0; g = 1'b0; end
    if (!rsm_rst_n)  begin s = s & ~16'hF700; e = e & ~16'hFB00; st = 0; end
    if (!core_rst_n) begin s[7:0] = '0; e[7:0] = '0; r = 1'b0; end
    m_sts = s; m_en = e; m_route = r; m_g3 = g; m_st = st;
  end

  // Compare every cycle, away from the active edge.
  always @(negedge clk) if (!done) begin : cmp
    logic work;
    logic [15:0] pend;
    work = (m_st == 0);
    pend = m_sts & m_en & 16'h7FFF;
    chk("R5 sci_o", {15'd0, sci}, {15'd0, work && m_route && pend != 0});
    chk("R6 smi_n_o", {15'd0, smi_n},
        {15'd0, !(work && !m_route && (pend & ~16'h0020) != 0)});
    chk("R4 wake_o", {15'd0, wake}, {15'd0, m_wake()});
    if (io_valid && !io_write) chk("R2 io_rdata_o", io_rdata, m_read(io_addr));
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    io_valid = 1'b1; io_write = 1'b1; io_addr = a; io_wdata = d;
    step();
    io_valid = 1'b0; io_write = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [15:0] exp, string tag);
    io_valid = 1'b1; io_write = 1'b0; io_addr = a;
    #1 chk(tag, io_rdata, exp);
    step();
    io_valid = 1'b0;
  endtask

  task automatic pulse_evt(logic [15:0] v);
    evt = v; step(); evt = '0;
  endtask

  task automatic pulse_fail();
    pwr_fail = 1'b1; step(); pwr_fail = 1'b0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL R1 watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin : main
    step(); step(); step();
    aon_rst_n = 1'b1; rsm_rst_n = 1'b1; core_rst_n = 1'b1;
    step();
    // R1 reset state
    rd(2'd0, 16'h0000, "R1 status after reset");
    rd(2'd1, 16'h0000, "R1 enable after reset");
    rd(2'd2, 16'h0000, "R1 control after reset");
    rd(2'd3, 16'h0000, "R1 state after reset");
    chk("R1 smi_n idle", {15'd0, smi_n}, 16'd1);

    // R2 enable register, bit 15 not implemented
    wr(2'd1, 16'h8521);
    rd(2'd1, 16'h0521, "R2 enable readback");
    pulse_evt(16'h0021);
    rd(2'd0, 16'h0021, "R2 status set by events");
    chk("R5 smi asserted by bit0", {15'd0, smi_n}, 16'd0);
    wr(2'd0, 16'h0000);
    rd(2'd0, 16'h0021, "R2 zero write keeps bits");
    wr(2'd0, 16'h0001);
    rd(2'd0, 16'h0020, "R2 one write clears bit0");
    chk("R6 bit5 gives no smi", {15'd0, smi_n}, 16'd1);
    wr(2'd2, 16'h0001);
    chk("R6 bit5 gives sci", {15'd0, sci}, 16'd1);
    wr(2'd0, 16'h0020);
    chk("R5 sci drops after clear", {15'd0, sci}, 16'd0);

    // R3 set wins over same-cycle clear; evt bit 15 ignored
    evt = 16'h8004; io_valid = 1'b1; io_write = 1'b1; io_addr = 2'd0; io_wdata = 16'h0004;
    step();
    evt = '0; io_valid = 1'b0; io_write = 1'b0;
    rd(2'd0, 16'h0004, "R3 set beats clear");
    wr(2'd0, 16'hFFFF);
    rd(2'd0, 16'h0000, "R2 clear all");

    // R4 / R7 sleep and wake
    wr(2'd2, 16'h0003);
    rd(2'd3, 16'h0001, "R4 entered sleep");
    rd(2'd2, 16'h0001, "R2 sleep bit reads zero");
    pulse_evt(16'h0001);
    chk("R7 no sci while sleeping", {15'd0, sci}, 16'd0);
    rd(2'd3, 16'h0001, "R6 bit0 does not wake");
    evt = 16'h0100; step(); evt = '0;
    chk("R4 wake_o raised", {15'd0, wake}, 16'd1);
    step();
    rd(2'd3, 16'h0000, "R4 back to working");
    rd(2'd0, 16'h8101, "R4 wake status set");
    chk("R7 sci after return", {15'd0, sci}, 16'd1);

    // R8 core reset
    core_rst_n = 1'b0; step(); core_rst_n = 1'b1;
    rd(2'd0, 16'h8100, "R8 core reset keeps high status");
    rd(2'd1, 16'h0500, "R8 core reset clears low enable");
    rd(2'd2, 16'h0000, "R8 core reset clears routing");

    // R10 power failure, soft-off enable clear
    pulse_fail();
    rd(2'd3, 16'h0000, "R10 working after failure");
    rd(2'd0, 16'h0000, "R10 wake status clear");
    rd(2'd1, 16'h0400, "R12 retained enable kept");

    // R11 power failure with soft-off enable
    pulse_evt(16'h0800);
    wr(2'd2, 16'h0004);
    pulse_fail();
    rd(2'd3, 16'h0002, "R11 soft-off after failure");
    rd(2'd0, 16'h0800, "R12 bit11 survives failure");
    rd(2'd2, 16'h0004, "R12 soft-off enable kept");
    pulse_evt(16'h0400);
    step();
    rd(2'd3, 16'h0000, "R11 alarm wake from soft-off");
    rd(2'd0, 16'h8C00, "R11 wake status after alarm");
    wr(2'd0, 16'hFFFF);
    pulse_fail();
    rd(2'd3, 16'h0002, "R11 soft-off again");
    pulse_evt(16'h0100);
    step();
    rd(2'd3, 16'h0000, "R11 power button wakes without enable");
    rd(2'd0, 16'h8100, "R11 wake status after button");

    // R9 resume reset
    pulse_evt(16'h0801);
    wr(2'd2, 16'h0006);
    rd(2'd3, 16'h0001, "R4 sleeping before resume reset");
    rsm_rst_n = 1'b0; step(); rsm_rst_n = 1'b1;
    rd(2'd3, 16'h0000, "R9 state working");
    rd(2'd0, 16'h0801, "R9 status high bits cleared");
    rd(2'd1, 16'h0400, "R9 enable bit10 kept");
    rd(2'd2, 16'h0004, "R12 soft-off enable kept");

    // R12 always-on reset
    aon_rst_n = 1'b0; step(); aon_rst_n = 1'b1;
    rd(2'd0, 16'h0001, "R12 aon reset clears bit11");
    rd(2'd1, 16'h0000, "R12 aon reset clears enable bit10");
    rd(2'd2, 16'h0000, "R12 aon reset clears soft-off enable");

    step(); step();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule